// File: doc/BRIEF.md
# Timer/Event Counter with Pulse-Width Capture

This block is an up-counting timer with a configurable width (8 bits by default). It has three counting sources. It can count the cycles in which the prescaled tick input is high. It can count transitions on an external timer input. It can also measure how long that external input stays at a chosen level, by counting ticks while the level holds. Software loads a start value into a preload register, chooses the mode and the polarity, and sets a run bit. When the counter passes its all-ones value, it reloads the preload value and raises a sticky request flag. The flag stays set until it is cleared.

In pulse-width capture the block takes one measurement and then stops. After the run bit is set, the block waits for the input to enter the active level. It counts ticks while the level is held. When the input leaves the level, the block clears its own run bit. The counter then holds the preload value plus the measured length, so software can read the result. The external input is asynchronous. It passes through a synchronizer chain before any edge or level decision is made.

Top module: `evt_timer`

## Requirements
- R1: After reset the counter, preload register, run bit and request flag are all zero.
- R2: A preload write while the run bit is 0 also loads the counter, and the new value is visible one clock later. A preload write while running changes only the preload register, and counting continues from the current value.
- R3: In mode 2'b10 (timer) with run set, the counter increments by one on each clock in which the tick input is high.
- R4: In mode 2'b01 (event) with run set, the counter increments once per rising edge of the external input when polarity is 1, and once per falling edge when polarity is 0. The increment appears on the third clock edge after the input changes (two synchronizer stages plus one history stage). The tick input has no effect in this mode.
- R5: An increment from the all-ones value loads the preload register value instead of zero and sets the request flag.
- R6: The request flag stays set until a clear pulse. If a clear and a new overflow happen in the same clock, the flag stays set.
- R7: In mode 2'b11 (pulse-width) with run set, counting starts only at the first entry into the active level (high for polarity 1, low for polarity 0) after the run write. A level that is already active when run is written is not measured. Ticks are counted while the level is held, including the entry cycle. On leaving the level the run bit clears by itself and the count is frozen.
- R8: With the run bit at 0, or with mode 2'b00, ticks and external edges leave the counter unchanged.
- R9: A control write (mode, polarity, run) never changes the counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaled internal count enable, one clock wide per tick |
| extIn | input | 1 | Asynchronous external timer input |
| ctrlWe | input | 1 | Control write strobe |
| modeIn | input | 2 | Mode: 00 off, 01 event, 10 timer, 11 pulse-width |
| polIn | input | 1 | 1 = rising edge / high level, 0 = falling edge / low level |
| runIn | input | 1 | Run bit value to write |
| preWe | input | 1 | Preload write strobe |
| preData | input | WIDTH | Preload value |
| flagClr | input | 1 | Clears the request flag |
| countOut | output | WIDTH | Current counter value |
| runOut | output | 1 | Current run bit |
| flagOut | output | 1 | Overflow request flag |

## Verification
Several rules are checked on every cycle by the assertions: the counter steps by exactly one or reloads from the preload register on overflow, a stopped write lands directly in the counter, the flag is sticky, an idle or control-only cycle leaves the count unchanged, and a pulse measurement that ends drops the run bit. The bench scenarios are needed for the rules that involve sequences. These are the three-clock latency from the external pin, the choice between rising and falling edges, and the rule that a level already active at the start is skipped. They also include the exact length measured for a held pulse and the end value after long random tick runs that wrap around several times.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PULSE = 2'b11
  } tmrMode_e;

  typedef enum logic [1:0] {
    PW_IDLE = 2'b00,
    PW_ARM  = 2'b01,
    PW_MEAS = 2'b10
  } pwState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic incEn;   // advance the counter this cycle
    logic loadNow; // copy preload write data into the counter
  } tmrStrobe_t;

endpackage

// File: rtl/tmr_ctl.sv
module tmr_ctl
  import evt_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       extIn,
  input  logic       ctrlWe,
  input  logic [1:0] modeIn,
  input  logic       polIn,
  input  logic       runIn,
  input  logic       preWe,
  output tmrStrobe_t strobe,
  output logic       runQ
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic     lvlPrev;
  tmrMode_e modeQ;
  logic     polQ;
  pwState_e pwState;

  logic actNow, actPrev, entry, exitEv, measuring;

  // input synchronizer and one history stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ   <= '0;
      lvlPrev <= 1'b0;
    end else begin
      syncQ   <= {syncQ[SYNC_STAGES-2:0], extIn};
      lvlPrev <= syncQ[LAST];
    end
  end

  // polarity folds level and edge choice into one "active" notion
  assign actNow  = polQ ? syncQ[LAST] : ~syncQ[LAST];
  assign actPrev = polQ ? lvlPrev : ~lvlPrev;
  assign entry   = actNow & ~actPrev;
  assign exitEv  = ~actNow & actPrev;

  assign measuring = (pwState == PW_MEAS) || ((pwState == PW_ARM) && entry);

  always_comb begin
    strobe.loadNow = preWe && !runQ;
    strobe.incEn   = 1'b0;
    if (runQ) begin
      unique case (modeQ)
        MODE_EVENT: strobe.incEn = entry;
        MODE_TIMER: strobe.incEn = tick;
        MODE_PULSE: strobe.incEn = tick && actNow && measuring;
        default:    strobe.incEn = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= MODE_OFF;
      polQ    <= 1'b0;
      runQ    <= 1'b0;
      pwState <= PW_IDLE;
    end else if (ctrlWe) begin
      modeQ   <= tmrMode_e'(modeIn);
      polQ    <= polIn;
      runQ    <= runIn;
      pwState <= (runIn && (tmrMode_e'(modeIn) == MODE_PULSE)) ? PW_ARM : PW_IDLE;
    end else if (runQ && (modeQ == MODE_PULSE)) begin
      unique case (pwState)
        PW_ARM:  if (entry) pwState <= PW_MEAS;
        PW_MEAS: if (exitEv) begin
          pwState <= PW_IDLE;
          runQ    <= 1'b0;
        end
        default: pwState <= PW_IDLE;
      endcase
    end
  end

  AST_PW_SELF_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && modeQ == MODE_PULSE && pwState == PW_MEAS && exitEv && !ctrlWe) |=> !runQ); // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_OFF) |-> !strobe.incEn); // R8
  AST_ARM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && modeQ == MODE_PULSE && pwState == PW_ARM && !entry && !ctrlWe) |=> (pwState == PW_ARM)); // R7

endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import evt_timer_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strobe,
  input  logic             preWe,
  input  logic [WIDTH-1:0] preData,
  input  logic             flagClr,
  output logic [WIDTH-1:0] cnt,
  output logic             flag
);

  localparam logic [WIDTH-1:0] TOP_VAL = '1;

  logic [WIDTH-1:0] preQ;
  logic             wrapNow;

  assign wrapNow = strobe.incEn && (cnt == TOP_VAL) && !strobe.loadNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preQ <= '0;
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (preWe) preQ <= preData;
      if (strobe.loadNow)    cnt <= preData;
      else if (wrapNow)      cnt <= preQ;
      else if (strobe.incEn) cnt <= cnt + 1'b1;
      flag <= wrapNow | (flag & ~flagClr);
    end
  end

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incEn && !strobe.loadNow && cnt != TOP_VAL) |=> (cnt == $past(cnt) + 1'b1)); // R3
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incEn && !strobe.loadNow && cnt == TOP_VAL && !preWe) |=> (cnt == $past(preQ) && flag)); // R5
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !flagClr) |=> flag); // R6
  AST_LOAD_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadNow |=> (cnt == $past(preData))); // R2

endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             extIn,
  input  logic             ctrlWe,
  input  logic [1:0]       modeIn,
  input  logic             polIn,
  input  logic             runIn,
  input  logic             preWe,
  input  logic [WIDTH-1:0] preData,
  input  logic             flagClr,
  output logic [WIDTH-1:0] countOut,
  output logic             runOut,
  output logic             flagOut
);

  tmrStrobe_t strobe;

  tmr_ctl #(.SYNC_STAGES(SYNC_STAGES)) uCtl (
    .clk(clk), .rstN(rstN), .tick(tick), .extIn(extIn),
    .ctrlWe(ctrlWe), .modeIn(modeIn), .polIn(polIn), .runIn(runIn),
    .preWe(preWe), .strobe(strobe), .runQ(runOut)
  );

  tmr_dp #(.WIDTH(WIDTH)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .preWe(preWe),
    .preData(preData), .flagClr(flagClr), .cnt(countOut), .flag(flagOut)
  );

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!runOut && !preWe) |=> $stable(countOut)); // R8
  AST_CTRL_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWe && !runOut && !preWe) |=> $stable(countOut)); // R9

endmodule

// File: tb/sim_evt_timer.sv
module sim_evt_timer;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b0, extIn = 1'b0, ctrlWe = 1'b0, polIn = 1'b0, runIn = 1'b0;
  logic preWe = 1'b0, flagClr = 1'b0;
  logic [1:0] modeIn = 2'b00;
  logic [W-1:0] preData = '0;
  logic [W-1:0] countOut;
  logic runOut, flagOut;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  evt_timer #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .tick(tick), .extIn(extIn), .ctrlWe(ctrlWe),
    .modeIn(modeIn), .polIn(polIn), .runIn(runIn), .preWe(preWe),
    .preData(preData), .flagClr(flagClr), .countOut(countOut),
    .runOut(runOut), .flagOut(flagOut)
  );

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCtl(logic [1:0] m, logic p, logic r);
    ctrlWe = 1'b1; modeIn = m; polIn = p; runIn = r;
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  task automatic wrPre(int v);
    preWe = 1'b1; preData = W'(v);
    @(negedge clk);
    preWe = 1'b0;
  endtask

  task automatic clrFlag();
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  task automatic ticks(int n, int gapMax);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      if (gapMax > 0) cyc($urandom_range(0, gapMax));
    end
  endtask

  task automatic pulseExt(logic act, int hold, int rest);
    extIn = act;  cyc(hold);
    extIn = ~act; cyc(rest);
  endtask

  // expected counter after n increments with reload-on-overflow
  function automatic void advance(input int s, input int p, input int n,
                                  output int v, output int ovf);
    v = s; ovf = 0;
    for (int i = 0; i < n; i++) begin
      if (v == (1 << W) - 1) begin v = p; ovf++; end
      else v++;
    end
  endfunction

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, ovf, p, n, k, s;
    void'($urandom(32'd4711));
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    chk("R1 count", countOut, 0);
    chk("R1 run", runOut, 0);
    chk("R1 flag", flagOut, 0);

    wrPre(8'h37);
    chk("R2 stopped load", countOut, 8'h37);
    wrCtl(2'b10, 1'b1, 1'b0);
    chk("R9 ctrl write", countOut, 8'h37);

    wrCtl(2'b10, 1'b1, 1'b1);
    chk("R9 run write", countOut, 8'h37);
    ticks(10, 2);
    chk("R3 timer ticks", countOut, 8'h41);
    wrPre(8'h05);
    chk("R2 running write", countOut, 8'h41);
    ticks(1, 0);
    chk("R2 continue", countOut, 8'h42);

    wrCtl(2'b10, 1'b1, 1'b0);
    ticks(5, 0);
    chk("R8 run off", countOut, 8'h42);
    wrCtl(2'b00, 1'b1, 1'b1);
    ticks(5, 0);
    pulseExt(1'b1, 3, 3);
    chk("R8 mode off", countOut, 8'h42);

    // overflow / reload
    wrCtl(2'b10, 1'b1, 1'b0);
    wrPre(8'hFE);
    clrFlag();
    wrCtl(2'b10, 1'b1, 1'b1);
    ticks(1, 0);
    chk("R5 at top", countOut, 8'hFF);
    chk("R5 no flag yet", flagOut, 0);
    ticks(1, 0);
    chk("R5 reload", countOut, 8'hFE);
    chk("R5 flag", flagOut, 1);
    cyc(5);
    chk("R6 sticky", flagOut, 1);
    clrFlag();
    chk("R6 cleared", flagOut, 0);
    ticks(1, 0);
    tick = 1'b1; flagClr = 1'b1;
    @(negedge clk);
    tick = 1'b0; flagClr = 1'b0;
    chk("R6 set wins", flagOut, 1);
    clrFlag();

    // event, rising
    wrCtl(2'b00, 1'b1, 1'b0);
    wrPre(10);
    wrCtl(2'b01, 1'b1, 1'b1);
    for (int i = 0; i < 4; i++) pulseExt(1'b1, 3, 3);
    cyc(4);
    chk("R4 rising", countOut, 14);
    ticks(5, 0);
    chk("R4 tick ignored", countOut, 14);

    // event, falling
    wrCtl(2'b01, 1'b0, 1'b0);
    extIn = 1'b1; cyc(5);
    wrPre(20);
    wrCtl(2'b01, 1'b0, 1'b1);
    for (int i = 0; i < 3; i++) pulseExt(1'b0, 2, 4);
    cyc(4);
    chk("R4 falling", countOut, 23);
    extIn = 1'b0;
    cyc(2);
    chk("R4 latency early", countOut, 23);
    cyc(1);
    chk("R4 latency third", countOut, 24);
    extIn = 1'b1; cyc(4);
    chk("R4 rising ignored", countOut, 24);

    // pulse width, high level, level already active at start
    wrCtl(2'b00, 1'b1, 1'b0);
    wrPre(0);
    tick = 1'b1;
    wrCtl(2'b11, 1'b1, 1'b1);
    cyc(6);
    chk("R7 preactive skipped", countOut, 0);
    chk("R7 armed run", runOut, 1);
    extIn = 1'b0; cyc(4);
    extIn = 1'b1; cyc(7);
    extIn = 0; cyc(5);
    chk("R7 width high", countOut, 7);
    chk("R7 self stop", runOut, 0);
    pulseExt(1'b1, 3, 4);
    chk("R7 one shot", countOut, 7);

    // pulse width, low level
    extIn = 1'b1; cyc(4);
    tick = 1'b0;
    wrPre(100);
    tick = 1'b1;
    wrCtl(2'b11, 1'b0, 1'b1);
    cyc(3);
    extIn = 1'b0; cyc(10);
    extIn = 1'b1; cyc(5);
    chk("R7 width low", countOut, 110);
    chk("R7 low self stop", runOut, 0);
    tick = 1'b0;

    // random timer runs
    for (int it = 0; it < 20; it++) begin
      p = $urandom_range(0, 255);
      n = $urandom_range(0, 600);
      wrCtl(2'b10, 1'b1, 1'b0);
      wrPre(p);
      clrFlag();
      wrCtl(2'b10, 1'b1, 1'b1);
      ticks(n, 2);
      advance(p, p, n, v, ovf);
      chk("R3 random count", countOut, v);
      chk("R5 random flag", flagOut, (ovf > 0) ? 1 : 0);
    end

    // random event runs
    extIn = 1'b0;
    for (int it = 0; it < 6; it++) begin
      wrCtl(2'b01, 1'b1, 1'b0);
      cyc(4);
      s = $urandom_range(0, 255);
      k = $urandom_range(1, 40);
      wrPre(s);
      wrCtl(2'b01, 1'b1, 1'b1);
      for (int i = 0; i < k; i++) pulseExt(1'b1, $urandom_range(1, 4), $urandom_range(1, 4));
      cyc(4);
      advance(s, s, k, v, ovf);
      chk("R4 random events", countOut, v);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule